// File: doc/BRIEF.md
# Raster Display Controller Register Bank

This block holds the eighteen 16-bit control words of a raster display controller. A host with an 8-bit data path reaches them by byte offset: the offset selects both the register and the byte half. Every register starts from a fixed default after reset. The horizontal and vertical timing generator, the pixel addressing unit and the frame memory are separate blocks. They read the stored words. The current raster line is fed back into this block as an input.

Three registers behave differently from plain storage. The status word gains its bit 0 whenever a frame-event pulse arrives, and any host read of it wipes it. The interrupt output is the AND of that status bit and an enable bit in the first control word. The last register is never read from storage: on a read it returns the raster line moved by the vertical blank end value and wrapped at the vertical total. A separate output reports display blanking, taken from the second control word.

Top module: `dispctl_regbank`

## Requirements
- R1: After a synchronous active-low reset, the registers hold the following values, listed by index. 0:0x0010, 1:0x0020, 2:0x01F0, 3:0x0200, 4:0x0004, 5:0x0010, 6:0x00F0, 7:0x0100, 11:0x7000, 12:0x0600, 14:0x0010. Every other index holds zero.
- R2: A host access uses register index = offset bits [6:2]. Offset bit 1 set selects the high byte [15:8], and clear selects the low byte [7:0]. Offset bit 0 has no effect. Read data is combinational and valid in the cycle `host_rd` is high. It is zero while `host_rd` is low.
- R3: A byte write takes effect at the next clock edge. It changes only the addressed byte and leaves the other byte of that register unchanged.
- R4: An index of 18 or above is outside the bank. Writes to it change no register, and reads from it return zero.
- R5: A pulse on `frame_evt` sets status register (index 13) bit 0 at the next clock edge.
- R6: `irq` is high exactly when status bit 0 and control-1 (index 11) bit 10 are both set. It follows a write to control-1 at the clock edge that stores the write.
- R7: A read of either byte of the status register returns the stored value in that cycle. The whole register is zero after the next clock edge, and `irq` falls with it.
- R8: If `frame_evt` and a status read occur in the same cycle, the status register holds 0x0001 after the edge.
- R9: A read of index 17 returns (`raster_line` + index-5 value) mod index-7 value. Data written to index 17 is stored but never returned. The block assumes both operands are below the index-7 value.
- R10: `blanked` is the inverse of control-2 (index 12) bit 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_wr | input | 1 | Byte write strobe |
| host_rd | input | 1 | Byte read strobe |
| host_addr | input | 7 | Byte offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data |
| frame_evt | input | 1 | One-cycle vertical interrupt event |
| raster_line | input | 16 | Current raster line from the timing generator |
| irq | output | 1 | Interrupt request |
| blanked | output | 1 | Display blanked indication |

## Verification
A mis-decoded index or a byte-merge fault puts wrong data into a register. That data appears at `host_rdata` on the first read of that index, or of the neighbouring byte, and the bench reads back the whole bank after every sweep. A status word that sets or clears on the wrong cycle shows on `irq` one edge after the event, the control write or the read. A wrong wrap in the line counter shows only when the sum crosses the vertical total. The bench therefore sweeps every line below two different totals.

// File: rtl/dctl_pkg.sv
// Shared constants and reset defaults for the display controller register bank.
// Assumes a fixed bank of 18 sixteen-bit words addressed by byte offset.
package dctl_pkg;
    localparam int REG_COUNT = 18;
    localparam int WORD_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 7;
    localparam int IDX_W     = ADDR_W - 2;

    localparam int IX_VBLANK_END = 5;
    localparam int IX_VTOTAL     = 7;
    localparam int IX_CTRL1      = 11;
    localparam int IX_CTRL2      = 12;
    localparam int IX_STATUS     = 13;
    localparam int IX_LINECOUNT  = 17;

    localparam int IRQ_EN_BIT = 10;
    localparam int BLANK_BIT  = 13;

    // Power-on value of each register by index.
    function automatic logic [WORD_W-1:0] reset_value(input int idx);
        case (idx)
            0:       return 16'h0010;
            1:       return 16'h0020;
            2:       return 16'h01F0;
            3:       return 16'h0200;
            4:       return 16'h0004;
            5:       return 16'h0010;
            6:       return 16'h00F0;
            7:       return 16'h0100;
            11:      return 16'h7000;
            12:      return 16'h0600;
            14:      return 16'h0010;
            default: return 16'h0000;
        endcase
    endfunction
endpackage

// File: rtl/dctl_store.sv
// Register storage with byte-lane writes.
// The status word also takes a set-on-event and a clear-on-read; a set in the
// same cycle as the clearing read wins. Indices at or above REG_COUNT match no word.
module dctl_store
    import dctl_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic                              rd_en,
    input  logic [IDX_W-1:0]                  idx,
    input  logic                              hi_sel,
    input  logic [BYTE_W-1:0]                 wdata,
    input  logic                              frame_evt,
    output logic [REG_COUNT-1:0][WORD_W-1:0]  regs_q
);
    for (genvar g = 0; g < REG_COUNT; g++) begin : g_word
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        logic             hit;
        logic [WORD_W-1:0] nxt;

        assign hit = (idx == MY_IDX);

        if (g == IX_STATUS) begin : g_status
            // Next status: byte write, then clear on read, then event set.
            always_comb begin
                nxt = regs_q[g];
                if (wr_en && hit) begin
                    if (hi_sel) nxt[WORD_W-1:BYTE_W] = wdata;
                    else        nxt[BYTE_W-1:0]      = wdata;
                end
                if (rd_en && hit) nxt = '0;
                if (frame_evt)    nxt[0] = 1'b1;
            end

            p_evt_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
                frame_evt |=> regs_q[g][0]);
            p_rd_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en && hit && !frame_evt) |=> (regs_q[g] == '0));
            p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en && hit && frame_evt) |=> (regs_q[g] == 16'h0001));
        end else begin : g_plain
            // Next value for a plain word: byte-lane merge on write.
            always_comb begin
                nxt = regs_q[g];
                if (wr_en && hit) begin
                    if (hi_sel) nxt[WORD_W-1:BYTE_W] = wdata;
                    else        nxt[BYTE_W-1:0]      = wdata;
                end
            end

            p_byte_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && hit && !hi_sel) |=> $stable(regs_q[g][WORD_W-1:BYTE_W]));
            p_byte_keep_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && hit && hi_sel) |=> $stable(regs_q[g][BYTE_W-1:0]));
        end

        // Register update with reset default.
        always_ff @(posedge clk) begin
            if (!rst_n) regs_q[g] <= reset_value(g);
            else        regs_q[g] <= nxt;
        end
    end

    p_oob_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(idx) >= REG_COUNT) && !frame_evt) |=> $stable(regs_q));
endmodule

// File: rtl/dctl_linecount.sv
// Scanline counter view: (line + offset) wrapped at total by one compare and subtract.
// Assumes line < total and offset < total, so one subtraction always suffices.
module dctl_linecount
    import dctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] line,
    input  logic [WORD_W-1:0] offset,
    input  logic [WORD_W-1:0] total,
    output logic [WORD_W-1:0] count
);
    logic [WORD_W:0] sum;
    logic [WORD_W:0] wrapped;

    // Sum and single conditional wrap.
    always_comb begin
        sum     = {1'b0, line} + {1'b0, offset};
        wrapped = sum - {1'b0, total};
        count   = (sum >= {1'b0, total}) ? wrapped[WORD_W-1:0] : sum[WORD_W-1:0];
    end

    p_count_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((line < total) && (offset < total)) |-> (count < total));
endmodule

// File: rtl/dctl_readmux.sv
// Host read path: selects a word by index, substitutes the live line count at
// its index, returns zero outside the bank or when no read is strobed.
module dctl_readmux
    import dctl_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rd_en,
    input  logic [IDX_W-1:0]                  idx,
    input  logic                              hi_sel,
    input  logic [REG_COUNT-1:0][WORD_W-1:0]  regs,
    input  logic [WORD_W-1:0]                 line_count,
    output logic [BYTE_W-1:0]                 rdata
);
    logic [WORD_W-1:0] word;

    // Word select by index with line-count substitution.
    always_comb begin
        word = '0;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (idx == IDX_W'(i)) word = (i == IX_LINECOUNT) ? line_count : regs[i];
        end
    end

    // Byte lane select, gated by the read strobe.
    always_comb begin
        rdata = '0;
        if (rd_en) rdata = hi_sel ? word[WORD_W-1:BYTE_W] : word[BYTE_W-1:0];
    end

    p_oob_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(idx) >= REG_COUNT) |-> (rdata == '0));
    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));
endmodule

// File: rtl/dispctl_regbank.sv
// Display controller register bank top: decodes the host byte offset, holds
// the words, forms the interrupt and blanking outputs.
// Assumes single-cycle strobes and raster_line below the vertical total.
module dispctl_regbank
    import dctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              frame_evt,
    input  logic [WORD_W-1:0] raster_line,
    output logic              irq,
    output logic              blanked
);
    logic [IDX_W-1:0]                 idx;
    logic                             hi_sel;
    logic                             unused_addr_lsb;
    logic [REG_COUNT-1:0][WORD_W-1:0] regs;
    logic [WORD_W-1:0]                line_count;

    // Offset decode: index from the upper bits, byte lane from bit 1.
    assign idx             = host_addr[ADDR_W-1:2];
    assign hi_sel          = host_addr[1];
    assign unused_addr_lsb = host_addr[0];

    dctl_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_wr),
        .rd_en     (host_rd),
        .idx       (idx),
        .hi_sel    (hi_sel),
        .wdata     (host_wdata),
        .frame_evt (frame_evt),
        .regs_q    (regs)
    );

    dctl_linecount u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .line   (raster_line),
        .offset (regs[IX_VBLANK_END]),
        .total  (regs[IX_VTOTAL]),
        .count  (line_count)
    );

    dctl_readmux u_rmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (host_rd),
        .idx        (idx),
        .hi_sel     (hi_sel),
        .regs       (regs),
        .line_count (line_count),
        .rdata      (host_rdata)
    );

    // Output flags from stored words.
    assign irq     = regs[IX_STATUS][0] & regs[IX_CTRL1][IRQ_EN_BIT];
    assign blanked = ~regs[IX_CTRL2][BLANK_BIT];

    p_irq_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && (int'(idx) == IX_STATUS) && !frame_evt) |=> !irq);
    p_irq_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_evt && host_wr && (int'(idx) == IX_CTRL1) && hi_sel
         && host_wdata[IRQ_EN_BIT-BYTE_W]) |=> irq);
endmodule

// File: tb/dispctl_regbank_test.sv
module dispctl_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [6:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        frame_evt = 1'b0;
    logic [15:0] raster_line = '0;
    logic        irq;
    logic        blanked;

    int total = 0;
    int bad = 0;
    logic [15:0] model [18];

    dispctl_regbank uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .frame_evt(frame_evt), .raster_line(raster_line), .irq(irq), .blanked(blanked)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] dflt(input int i);
        case (i)
            0: return 16'h0010;  1: return 16'h0020;  2: return 16'h01F0;
            3: return 16'h0200;  4: return 16'h0004;  5: return 16'h0010;
            6: return 16'h00F0;  7: return 16'h0100;  11: return 16'h7000;
            12: return 16'h0600; 14: return 16'h0010;
            default: return 16'h0000;
        endcase
    endfunction

    // Write one byte; takes effect at the single posedge inside the task.
    task automatic wr_byte(input int idx, input bit hi, input logic [7:0] d, input bit lsb = 0);
        @(negedge clk);
        host_addr  = 7'((idx << 2) | (hi ? 2 : 0) | (lsb ? 1 : 0));
        host_wdata = d;
        host_wr    = 1'b1;
        @(posedge clk);
        #1 host_wr = 1'b0;
    endtask

    // Read one byte; data sampled before the edge, strobe spans one edge.
    task automatic rd_byte(input int idx, input bit hi, output logic [7:0] d, input bit evt = 0);
        @(negedge clk);
        host_addr = 7'((idx << 2) | (hi ? 2 : 0));
        host_rd   = 1'b1;
        frame_evt = evt;
        #2 d = host_rdata;
        @(posedge clk);
        #1 host_rd = 1'b0;
        frame_evt = 1'b0;
    endtask

    task automatic pulse_evt();
        @(negedge clk);
        frame_evt = 1'b1;
        @(posedge clk);
        #1 frame_evt = 1'b0;
    endtask

    task automatic check_bank(input string req);
        logic [7:0] d;
        for (int i = 0; i < 17; i++) begin
            if (i == 13) continue;
            rd_byte(i, 0, d); chk(req, d, model[i][7:0]);
            rd_byte(i, 1, d); chk(req, d, model[i][15:8]);
        end
    endtask

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int vb, vt, e;
        repeat (3) @(posedge clk);
        #1;
        chk("R2 idle rdata", host_rdata, 0);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state of all words (index 17 returns a count, checked later)
        for (int i = 0; i < 18; i++) model[i] = dflt(i);
        check_bank("R1 reset");
        rd_byte(13, 0, d); chk("R1 status reset", d, 0);
        chk("R10 blanked at reset", blanked, 1);
        chk("R6 irq at reset", irq, 0);

        // R3 byte-lane writes across the bank
        for (int i = 0; i < 17; i++) begin
            if (i == 13) continue;
            wr_byte(i, 0, 8'(i * 7 + 3));
            model[i][7:0] = 8'(i * 7 + 3);
            rd_byte(i, 1, d); chk("R3 high kept", d, model[i][15:8]);
            rd_byte(i, 0, d); chk("R3 low written", d, model[i][7:0]);
            wr_byte(i, 1, 8'(8'hF0 ^ i));
            model[i][15:8] = 8'(8'hF0 ^ i);
            rd_byte(i, 0, d); chk("R3 low kept", d, model[i][7:0]);
        end
        check_bank("R3 bank");

        // R2 offset bit 0 ignored
        wr_byte(2, 0, 8'h5A, 1);
        model[2][7:0] = 8'h5A;
        rd_byte(2, 0, d); chk("R2 lsb ignored", d, 8'h5A);

        // R4 out-of-range writes and reads
        for (int i = 18; i < 32; i++) begin
            wr_byte(i, 0, 8'hC3);
            wr_byte(i, 1, 8'h3C);
            rd_byte(i, 0, d); chk("R4 oob read", d, 0);
            rd_byte(i, 1, d); chk("R4 oob read", d, 0);
        end
        check_bank("R4 bank untouched");

        // Restore control words to defaults for the flag tests
        wr_byte(11, 0, 8'h00); wr_byte(11, 1, 8'h70);
        wr_byte(12, 0, 8'h00); wr_byte(12, 1, 8'h06);

        // R10 blanking flag
        #1 chk("R10 blanked ctrl2 bit13 clear", blanked, 1);
        wr_byte(12, 1, 8'h26);
        #1 chk("R10 blanked ctrl2 bit13 set", blanked, 0);
        wr_byte(12, 1, 8'h06);
        #1 chk("R10 blanked cleared again", blanked, 1);

        // R5 event sets status, R6 masked irq
        pulse_evt();
        #1 chk("R6 irq masked", irq, 0);
        wr_byte(11, 1, 8'h74);
        #1 chk("R6 irq after enable write", irq, 1);
        // R7 read returns value then clears
        rd_byte(13, 1, d); chk("R7 status high byte", d, 0);
        #1 chk("R7 irq dropped", irq, 0);
        rd_byte(13, 0, d); chk("R7 status cleared", d, 0);
        pulse_evt();
        rd_byte(13, 0, d); chk("R5 status bit0 set", d, 1);
        #1 chk("R7 irq dropped after low read", irq, 0);
        // R8 set wins over clearing read
        pulse_evt();
        rd_byte(13, 0, d, 1); chk("R8 read value", d, 1);
        #1 chk("R8 irq kept", irq, 1);
        rd_byte(13, 0, d); chk("R8 status after tie", d, 1);
        rd_byte(13, 0, d); chk("R8 then cleared", d, 0);
        wr_byte(11, 1, 8'h70);
        pulse_evt();
        #1 chk("R6 irq off with enable clear", irq, 0);
        rd_byte(13, 0, d);

        // R9 line counter sweeps
        wr_byte(17, 0, 8'hEE); wr_byte(17, 1, 8'hEE);
        for (int pass = 0; pass < 2; pass++) begin
            vt = (pass == 0) ? 40 : 16'h0105;
            vb = (pass == 0) ? 13 : 16'h0100;
            wr_byte(7, 0, 8'(vt)); wr_byte(7, 1, 8'(vt >> 8));
            wr_byte(5, 0, 8'(vb)); wr_byte(5, 1, 8'(vb >> 8));
            for (int ln = 0; ln < vt; ln++) begin
                raster_line = 16'(ln);
                e = (ln + vb) % vt;
                rd_byte(17, 0, d); chk("R9 count low", d, e & 8'hFF);
                rd_byte(17, 1, d); chk("R9 count high", d, (e >> 8) & 8'hFF);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule